// File: doc/BRIEF.md
# Per-Byte Write-Length Mask Generator

This block turns a short write-length code, given with each write, into a per-beat data mask for a double-data-rate write burst. It does not use a dedicated mask pin. Each byte lane has its own code, so on a two-lane (16-bit) memory the upper and lower bytes can stop writing at different points in the same burst. The beats after the requested length are masked.

The burst length (two or four beats) and the address order (sequential or interleaved) are held in a small mode register. The values in that register are captured when a burst starts.

For each beat the block presents three things: the beat number, the column offset that beat addresses, and one mask bit per lane. The offset is produced without carry past the burst boundary. The block runs on a clock at the beat rate, so each beat lasts one cycle. Every output comes from a register, so the mask for a beat is ready one beat before the data edge it controls. Driving the data pins is left to the logic downstream.

Top module: `wl_mask_gen`

## Requirements
- R1: While reset is asserted and afterwards until the first burst start, `beat_valid` is 0, `beat_mask` is all zeros, and `beat_idx` and `beat_col` are 0.
- R2: The cycle after `burst_start` is sampled high, `beat_valid` is 1 with `beat_idx` 0. `beat_idx` then counts up by one per cycle through burst-length minus one. In the following cycle `beat_valid` returns to 0.
- R3: A `mode_load` pulse stores `mode_long` (1 = four-beat bursts, 0 = two-beat bursts) and `mode_ilv` (1 = interleaved order, 0 = sequential order). The reset value is four-beat sequential.
- R4: In sequential order, the low log2(burst length) bits of `beat_col` equal (start column + beat index) modulo the burst length. The higher bits of `start_col` pass through unchanged, so there is no carry out of the burst block.
- R5: In interleaved order, `beat_col` equals `start_col` XOR `beat_idx`.
- R6: A lane whose code k lies between 1 and burst length minus one writes beats 0 through k-1. Its mask bit is 1 (masked) on every later beat of the burst.
- R7: A code of 0, the all-ones code (3 for the default 2-bit codes), or any code not smaller than the burst length writes every beat: the mask bit stays 0 for the whole burst.
- R8: Lane 0 (the lower byte) takes `wl_len[1:0]` and drives `beat_mask[0]`. Lane 1 (the upper byte) takes `wl_len[3:0]` bits 3:2 and drives `beat_mask[1]`. The two lanes mask independently of each other.
- R9: The mode, `start_col` and `wl_len` are captured on the cycle `burst_start` is sampled. Changes to them while a burst is in progress, including a `mode_load`, do not alter that burst.
- R10: A `burst_start` during a burst abandons the old burst. The next cycle shows beat 0 of the new burst with the new parameters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Beat-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | Store `mode_long` and `mode_ilv` in the mode register |
| mode_long | input | 1 | 1 = four-beat bursts, 0 = two-beat bursts |
| mode_ilv | input | 1 | 1 = interleaved column order, 0 = sequential |
| burst_start | input | 1 | Begin a write burst (second command of the pair) |
| start_col | input | BEAT_W (2) | Starting low column bits |
| wl_len | input | LANES*LEN_W (4) | Write-length codes, lane 0 in the lowest bits |
| beat_valid | output | 1 | A beat is being presented |
| beat_idx | output | BEAT_W (2) | Beat number within the burst |
| beat_col | output | BEAT_W (2) | Column offset of this beat |
| beat_mask | output | LANES (2) | Per-lane mask, 1 = beat not written |

## Verification
The hardest conditions to reach are those where the burst parameters change while a burst is in flight. These are a mode reload or new length codes in the middle of a burst, which the block must ignore, and a second start that must cut the first burst short.

The stimulus reaches them with directed sequences. Each one changes the inputs exactly one cycle after a burst start, then follows every remaining beat at the ports. One sequence fires a new start while beat 1 of the old burst is on the outputs.

A table of start columns, orders, burst lengths and code pairs covers the column wrap at the block boundary. The same table covers the clamping of out-of-range codes against a two-beat burst.

// File: rtl/wl_pkg.sv
package wl_pkg;

  typedef enum logic {BT_SEQ = 1'b0, BT_ILV = 1'b1} burst_type_e;

  typedef struct packed {
    logic        long_burst;
    burst_type_e btype;
  } mode_t;

  // Number of beats a lane writes for a given length code.
  function automatic int eff_len(int code, int code_max, int bl);
    if (code == 0 || code == code_max || code >= bl) return bl;
    return code;
  endfunction

  // Column offset of a beat; the wrap stays inside the burst block.
  function automatic int beat_col(int start, int idx, int bl, logic ilv);
    int m;
    m = bl - 1;
    if (ilv) return start ^ idx;
    return (start & ~m) | ((start + idx) & m);
  endfunction

endpackage

// File: rtl/wl_mode_reg.sv
module wl_mode_reg
  import wl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  logic  long_in,
  input  logic  ilv_in,
  output mode_t mode_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q.long_burst <= 1'b1;
      mode_q.btype      <= BT_SEQ;
    end else if (load) begin
      mode_q.long_burst <= long_in;
      mode_q.btype      <= ilv_in ? BT_ILV : BT_SEQ;
    end
  end

endmodule

// File: rtl/wl_beat_seq.sv
module wl_beat_seq
  import wl_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mode_t             mode_in,
  input  logic [BEAT_W-1:0] col_in,
  output logic              active,
  output logic [BEAT_W-1:0] idx,
  output logic [BEAT_W-1:0] col
);

  localparam int MAXBL = 1 << BEAT_W;

  logic              active_q;
  logic [BEAT_W-1:0] idx_q;
  logic [BEAT_W-1:0] col0_q;
  mode_t             mode_q;
  logic [BEAT_W:0]   bl_cur;
  logic              last_beat;

  assign bl_cur    = mode_q.long_burst ? (BEAT_W+1)'(MAXBL) : (BEAT_W+1)'(MAXBL / 2);
  assign last_beat = active_q && ({1'b0, idx_q} == bl_cur - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      col0_q   <= '0;
      mode_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
      col0_q   <= col_in;
      mode_q   <= mode_in;
    end else if (active_q) begin
      if (last_beat) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign active = active_q;
  assign idx    = idx_q;
  assign col    = active_q
                ? BEAT_W'(beat_col(int'(col0_q), int'(idx_q), int'(bl_cur),
                                   mode_q.btype == BT_ILV))
                : '0;

  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active && idx == '0);
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    active && !start && !last_beat |=> active && idx == $past(idx) + 1'b1);
  a_r2_end: assert property (@(posedge clk) disable iff (!rst_n)
    active && last_beat && !start |=> !active);
  a_r1_idle_col: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> col == '0 && idx == '0);

endmodule

// File: rtl/wl_lane_mask.sv
module wl_lane_mask
  import wl_pkg::*;
#(
  parameter int BEAT_W = 2,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  code_in,
  input  logic [BEAT_W:0]   bl_start,
  input  logic              active,
  input  logic [BEAT_W-1:0] idx,
  output logic              mask
);

  localparam int CODE_MAX = (1 << LEN_W) - 1;

  logic [BEAT_W:0] len_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     len_q <= '0;
    else if (start) len_q <= (BEAT_W+1)'(eff_len(int'(code_in), CODE_MAX, int'(bl_start)));
  end

  assign mask = active && ({1'b0, idx} >= len_q);

  a_r6_first_beat_written: assert property (@(posedge clk) disable iff (!rst_n)
    active && idx == '0 |-> !mask);
  a_r6_mask_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    active && mask && !start |=> !active || mask);
  a_r1_idle_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mask);

endmodule

// File: rtl/wl_mask_gen.sv
module wl_mask_gen
  import wl_pkg::*;
#(
  parameter int BEAT_W = 2,
  parameter int LEN_W  = 2,
  parameter int LANES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_load,
  input  logic                   mode_long,
  input  logic                   mode_ilv,
  input  logic                   burst_start,
  input  logic [BEAT_W-1:0]      start_col,
  input  logic [LANES*LEN_W-1:0] wl_len,
  output logic                   beat_valid,
  output logic [BEAT_W-1:0]      beat_idx,
  output logic [BEAT_W-1:0]      beat_col,
  output logic [LANES-1:0]       beat_mask
);

  localparam int MAXBL = 1 << BEAT_W;

  mode_t           mode_cur;
  logic [BEAT_W:0] bl_new;

  wl_mode_reg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (mode_load),
    .long_in (mode_long),
    .ilv_in  (mode_ilv),
    .mode_q  (mode_cur)
  );

  assign bl_new = mode_cur.long_burst ? (BEAT_W+1)'(MAXBL) : (BEAT_W+1)'(MAXBL / 2);

  wl_beat_seq #(.BEAT_W(BEAT_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (burst_start),
    .mode_in (mode_cur),
    .col_in  (start_col),
    .active  (beat_valid),
    .idx     (beat_idx),
    .col     (beat_col)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wl_lane_mask #(.BEAT_W(BEAT_W), .LEN_W(LEN_W)) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (burst_start),
      .code_in  (wl_len[l*LEN_W +: LEN_W]),
      .bl_start (bl_new),
      .active   (beat_valid),
      .idx      (beat_idx),
      .mask     (beat_mask[l])
    );
  end

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && burst_start |=> beat_valid && beat_idx == '0 && beat_mask == '0);

endmodule

// File: tb/test_wl_mask_gen.sv
module test_wl_mask_gen;

  localparam int CLK_P = 10;
  localparam int NVEC  = 10;
  // {long, ilv, col[1:0], upper code[1:0], lower code[1:0]}
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'd0, 2'd1, 2'd2},
    {1'b1, 1'b0, 2'd1, 2'd3, 2'd0},
    {1'b1, 1'b0, 2'd3, 2'd2, 2'd1},
    {1'b1, 1'b1, 2'd1, 2'd1, 2'd3},
    {1'b1, 1'b1, 2'd2, 2'd2, 2'd2},
    {1'b1, 1'b1, 2'd3, 2'd0, 2'd1},
    {1'b0, 1'b0, 2'd0, 2'd1, 2'd2},
    {1'b0, 1'b0, 2'd3, 2'd3, 2'd1},
    {1'b0, 1'b1, 2'd2, 2'd2, 2'd1},
    {1'b0, 1'b0, 2'd1, 2'd1, 2'd3}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_load = 1'b0, mode_long = 1'b0, mode_ilv = 1'b0;
  logic       burst_start = 1'b0;
  logic [1:0] start_col = '0;
  logic [3:0] wl_len = '0;
  logic       beat_valid;
  logic [1:0] beat_idx, beat_col, beat_mask;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  wl_mask_gen i_wl_mask_gen (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load), .mode_long(mode_long),
    .mode_ilv(mode_ilv), .burst_start(burst_start), .start_col(start_col),
    .wl_len(wl_len), .beat_valid(beat_valid), .beat_idx(beat_idx),
    .beat_col(beat_col), .beat_mask(beat_mask)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    applied++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0d, expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // Expected beats written for a code, from R6/R7.
  function automatic int model_len(int code, int bl);
    if (code == 0 || code == 3) return bl;
    return (code > bl) ? bl : code;
  endfunction

  // Expected column, from R4/R5.
  function automatic int model_col(int col, int b, int bl, bit ilv);
    int base, v;
    if (ilv) return col ^ b;
    base = col - (col % bl);
    v = (col % bl) + b;
    if (v >= bl) v = v - bl;
    return base + v;
  endfunction

  task automatic expect_beat(int b, int bl, bit ilv, int col, int lu, int ll);
    int ec, mu, ml;
    ec = model_col(col, b, bl, ilv);
    mu = (b >= model_len(lu, bl)) ? 1 : 0;
    ml = (b >= model_len(ll, bl)) ? 1 : 0;
    check(beat_valid === 1'b1, "R2 valid", int'(beat_valid), 1);
    check(beat_idx == b, "R2 idx", int'(beat_idx), b);
    check(beat_col == ec, ilv ? "R5 col" : "R4 col", int'(beat_col), ec);
    check(beat_mask[0] == ml, (ll == 0 || ll == 3 || ll >= bl) ? "R7 lower" : "R6 lower",
          int'(beat_mask[0]), ml);
    check(beat_mask[1] == mu, "R8 upper", int'(beat_mask[1]), mu);
  endtask

  task automatic load_mode(bit lng, bit ilv);
    mode_load = 1'b1; mode_long = lng; mode_ilv = ilv;
    tick();
    mode_load = 1'b0;
  endtask

  task automatic run_burst(bit lng, bit ilv, int col, int lu, int ll);
    int bl;
    bl = lng ? 4 : 2;
    burst_start = 1'b1; start_col = 2'(col); wl_len = {2'(lu), 2'(ll)};
    tick();
    burst_start = 1'b0;
    for (int b = 0; b < bl; b++) begin
      expect_beat(b, bl, ilv, col, lu, ll);
      tick();
    end
    check(beat_valid === 1'b0, "R2 end", int'(beat_valid), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got 0, expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) tick();
    check(beat_valid === 1'b0, "R1 valid in reset", int'(beat_valid), 0);
    check(beat_mask === 2'b00, "R1 mask in reset", int'(beat_mask), 0);
    rst_n = 1'b1;
    tick();
    check(beat_valid === 1'b0 && beat_idx == 0 && beat_col == 0, "R1 idle after reset",
          int'(beat_valid), 0);
    check(beat_mask === 2'b00, "R1 idle mask", int'(beat_mask), 0);

    // R3: reset mode is four-beat sequential
    run_burst(1'b1, 1'b0, 1, 3, 3);

    // Table of vectors, R3..R8
    for (int v = 0; v < NVEC; v++) begin
      load_mode(VEC[v][7], VEC[v][6]);
      run_burst(VEC[v][7], VEC[v][6], int'(VEC[v][5:4]), int'(VEC[v][3:2]), int'(VEC[v][1:0]));
    end

    // R9: mode and inputs changed mid-burst are ignored
    load_mode(1'b1, 1'b0);
    burst_start = 1'b1; start_col = 2'd0; wl_len = {2'd2, 2'd2};
    tick();
    burst_start = 1'b0;
    mode_load = 1'b1; mode_long = 1'b0; mode_ilv = 1'b1;
    start_col = 2'd3; wl_len = {2'd1, 2'd1};
    expect_beat(0, 4, 1'b0, 0, 2, 2);
    tick();
    mode_load = 1'b0;
    for (int b = 1; b < 4; b++) begin
      expect_beat(b, 4, 1'b0, 0, 2, 2);
      tick();
    end
    check(beat_valid === 1'b0, "R9 burst kept four beats", int'(beat_valid), 0);
    // R3: the reloaded mode (two-beat interleaved) takes effect on the next burst
    run_burst(1'b0, 1'b1, 1, 1, 2);

    // R10: restart while beat 1 is presented
    load_mode(1'b1, 1'b0);
    burst_start = 1'b1; start_col = 2'd0; wl_len = {2'd1, 2'd1};
    tick();
    burst_start = 1'b0;
    expect_beat(0, 4, 1'b0, 0, 1, 1);
    tick();
    expect_beat(1, 4, 1'b0, 0, 1, 1);
    burst_start = 1'b1; start_col = 2'd2; wl_len = {2'd2, 2'd3};
    tick();
    burst_start = 1'b0;
    check(beat_idx == 0, "R10 restart idx", int'(beat_idx), 0);
    for (int b = 0; b < 4; b++) begin
      expect_beat(b, 4, 1'b0, 2, 2, 3);
      tick();
    end
    check(beat_valid === 1'b0, "R10 end", int'(beat_valid), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

endmodule